// File: doc/BRIEF.md
# TLB Entry Access Control Registers

This block holds a small set-associative table of address translation entries that software fills and inspects on its own. It does no lookup for ordinary memory traffic. Software sees three registers through one control-register port: a page register with the virtual page number, a control register with process ID, way select, write-enable, read trigger and double-miss flag, and an access register with the entry's data word (frame number and permission bits).

Entries move only on an explicit request. A write to the access register while write-enable is 1 stores an entry. The entry's set is the low bits of the page number. Its tag is the upper page-number bits plus the process ID. The way counter then steps to the next way. Writing 1 to the read-trigger bit loads the three registers from the selected entry. Exception reports from the pipeline update write-enable and the double-miss flag, so a miss or permission handler can refill an entry at once.

A two-state machine sequences reads. `ST_IDLE` accepts register writes. A write with the read trigger set takes the transition `IDLE->RD_LOAD` and registers the entry read. `ST_RD_LOAD` loads the registers from that read and always takes `RD_LOAD->IDLE`.

Top module: `tlb_ctl_regs`

## Requirements
- R1: After reset the page, control and access registers read 0, the way field is 0, write-enable and double-miss are 0, and every entry is invalid.
- R2: A write to the page register, or to the control register with bit 0 clear, leaves the access register unchanged.
- R3: Address 2 is the access register. A write to it while write-enable is 1 loads the register and stores {page[VPN_W-1:SET_W], process ID, data}, marked valid, at set page[SET_W-1:0] and the current way.
- R4: A write to the access register while write-enable is 0 loads only that register: no entry changes and the way field holds.
- R5: Each stored entry advances the way field by one, and it wraps from NUM_WAYS-1 to 0.
- R6: Control register (address 1) layout: bit 0 is the read trigger and reads 0. Bit 1 is write-enable. Bit 2 is double-miss, and writes to it are ignored. Bits 7:4 are the way, and a written value of NUM_WAYS or more loads 0. Bits 16+PID_W-1:16 are the process ID. Every other bit reads 0, and address 3 reads 0.
- R7: A control write with bit 0 set selects the entry at page[SET_W-1:0] and the way carried in that write. One clock after that write has been taken, the access register, page[VPN_W-1:SET_W] and the process ID hold the entry's values. The entry's process ID wins over the one in the write.
- R8: A read of an invalid entry loads 0 into the access register, the upper page bits and the process ID, and keeps page[SET_W-1:0].
- R9: A reported exception sets write-enable to 1 when it is a permission violation, or when it is a miss while handler-active is 0. Otherwise write-enable keeps its value.
- R10: Every reported exception loads the double-miss flag from the double-miss input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 2 | Register select: 0 page, 1 control, 2 access, 3 none |
| csr_wen | input | 1 | Write strobe for the selected register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected register (combinational) |
| exc_valid | input | 1 | An exception is reported this cycle |
| exc_tlb_miss | input | 1 | The reported exception is a translation miss |
| exc_tlb_perm | input | 1 | The reported exception is a permission violation |
| exc_dbl_miss | input | 1 | The reported exception is a double miss |
| exc_handler_active | input | 1 | The exception handler was already running |

## Verification
The checks assume that no register write arrives in the cycle after a read trigger, while the machine is in `ST_RD_LOAD`. One assertion guards this assumption, and the bench always leaves that cycle idle. The checks also assume that the exception flags are known whenever `exc_valid` is high. The bench drives every input to 0 from time zero and never reports an exception in the same cycle as a register write, so the write-enable priority rule is never at stake.

// File: rtl/tlb_ctl_pkg.sv
package tlb_ctl_pkg;

    typedef enum logic [1:0] {
        CSR_PAGE = 2'd0,
        CSR_MISC = 2'd1,
        CSR_ACC  = 2'd2,
        CSR_NONE = 2'd3
    } csr_addr_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RD_LOAD = 1'b1
    } rd_state_e;

    localparam int MISC_RD_BIT  = 0;
    localparam int MISC_WE_BIT  = 1;
    localparam int MISC_DBL_BIT = 2;
    localparam int MISC_WAY_LSB = 4;
    localparam int MISC_WAY_FW  = 4;
    localparam int MISC_PID_LSB = 16;

endpackage

// File: rtl/tlb_way_ctr.sv
module tlb_way_ctr #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WAY_W-1:0] load_val,
    input  logic             inc,
    output logic [WAY_W-1:0] way_q
);
    localparam logic [WAY_W-1:0] LAST = WAY_W'(NUM_WAYS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_q <= '0;
        end else if (load) begin
            way_q <= load_val;
        end else if (inc) begin
            way_q <= (way_q == LAST) ? '0 : way_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_flag_unit.sv
module tlb_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr,
    input  logic sw_we,
    input  logic exc_valid,
    input  logic exc_tlb_miss,
    input  logic exc_tlb_perm,
    input  logic exc_dbl_miss,
    input  logic exc_handler_active,
    output logic we_q,
    output logic dbl_q
);
    logic hw_set_we;

    always_comb begin
        hw_set_we = exc_valid &&
                    (exc_tlb_perm || (exc_tlb_miss && !exc_handler_active));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q  <= 1'b0;
            dbl_q <= 1'b0;
        end else begin
            if (exc_valid) begin
                dbl_q <= exc_dbl_miss;
            end
            if (hw_set_we) begin
                we_q <= 1'b1;
            end else if (sw_wr) begin
                we_q <= sw_we;
            end
        end
    end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 18,
    parameter int PID_W = 8,
    parameter int ACC_W = 24,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PID_W-1:0] rd_pid,
    output logic [ACC_W-1:0] rd_data
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [PID_W-1:0]   pid_q  [ENTRIES];
    logic [ACC_W-1:0]   data_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            pid_q[wr_idx]  <= wr_pid;
            data_q[wr_idx] <= wr_data;
        end
    end

    // registered read port; an invalid entry returns all zeros
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_tag  <= '0;
            rd_pid  <= '0;
            rd_data <= '0;
        end else if (rd_en) begin
            if (valid_q[rd_idx]) begin
                rd_tag  <= tag_q[rd_idx];
                rd_pid  <= pid_q[rd_idx];
                rd_data <= data_q[rd_idx];
            end else begin
                rd_tag  <= '0;
                rd_pid  <= '0;
                rd_data <= '0;
            end
        end
    end
endmodule

// File: rtl/tlb_ctl_regs.sv
module tlb_ctl_regs #(
    parameter int VPN_W    = 20,
    parameter int SET_W    = 2,
    parameter int NUM_WAYS = 4,
    parameter int PID_W    = 8,
    parameter int ACC_W    = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  csr_addr,
    input  logic        csr_wen,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        exc_valid,
    input  logic        exc_tlb_miss,
    input  logic        exc_tlb_perm,
    input  logic        exc_dbl_miss,
    input  logic        exc_handler_active
);
    import tlb_ctl_pkg::*;

    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int IDX_W = SET_W + WAY_W;
    localparam logic [MISC_WAY_FW:0] NW_CMP = (MISC_WAY_FW + 1)'(NUM_WAYS);

    csr_addr_e        addr_e;
    rd_state_e        state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [PID_W-1:0] pid_q;
    logic [ACC_W-1:0] acc_q;
    logic [WAY_W-1:0] way_q;
    logic             we_q, dbl_q;
    logic             csr_take, wr_page, wr_misc, wr_acc, rd_trig, commit;
    logic             rd_issue, load_from_store;
    logic [MISC_WAY_FW-1:0] way_field;
    logic [WAY_W-1:0] way_sel;
    logic [TAG_W-1:0] st_tag;
    logic [PID_W-1:0] st_pid;
    logic [ACC_W-1:0] st_data;

    // ---------------- write decode ----------------
    always_comb begin
        addr_e    = csr_addr_e'(csr_addr);
        csr_take  = csr_wen && (state_q == ST_IDLE);
        wr_page   = csr_take && (addr_e == CSR_PAGE);
        wr_misc   = csr_take && (addr_e == CSR_MISC);
        wr_acc    = csr_take && (addr_e == CSR_ACC);
        rd_trig   = wr_misc && csr_wdata[MISC_RD_BIT];
        commit    = wr_acc && we_q;
        way_field = csr_wdata[MISC_WAY_LSB +: MISC_WAY_FW];
        way_sel   = ({1'b0, way_field} < NW_CMP) ? way_field[WAY_W-1:0] : '0;
    end

    // ---------------- read sequencer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = rd_trig ? ST_RD_LOAD : ST_IDLE;
            ST_RD_LOAD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_issue        = 1'b0;
        load_from_store = 1'b0;
        unique case (state_q)
            ST_IDLE:    rd_issue = rd_trig;
            ST_RD_LOAD: load_from_store = 1'b1;
            default:    load_from_store = 1'b0;
        endcase
    end

    // ---------------- submodules ----------------
    tlb_way_ctr #(.NUM_WAYS(NUM_WAYS)) i_way (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_misc),
        .load_val (way_sel),
        .inc      (commit),
        .way_q    (way_q)
    );

    tlb_flag_unit i_flags (
        .clk                (clk),
        .rst_n              (rst_n),
        .sw_wr              (wr_misc),
        .sw_we              (csr_wdata[MISC_WE_BIT]),
        .exc_valid          (exc_valid),
        .exc_tlb_miss       (exc_tlb_miss),
        .exc_tlb_perm       (exc_tlb_perm),
        .exc_dbl_miss       (exc_dbl_miss),
        .exc_handler_active (exc_handler_active),
        .we_q               (we_q),
        .dbl_q              (dbl_q)
    );

    tlb_entry_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .PID_W (PID_W),
        .ACC_W (ACC_W)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  ({vpn_q[SET_W-1:0], way_q}),
        .wr_tag  (vpn_q[VPN_W-1:SET_W]),
        .wr_pid  (pid_q),
        .wr_data (csr_wdata[ACC_W-1:0]),
        .rd_en   (rd_issue),
        .rd_idx  ({vpn_q[SET_W-1:0], way_sel}),
        .rd_tag  (st_tag),
        .rd_pid  (st_pid),
        .rd_data (st_data)
    );

    // ---------------- software-visible registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q <= '0;
            pid_q <= '0;
            acc_q <= '0;
        end else if (load_from_store) begin
            vpn_q[VPN_W-1:SET_W] <= st_tag;
            pid_q                <= st_pid;
            acc_q                <= st_data;
        end else begin
            if (wr_page) vpn_q <= csr_wdata[VPN_W-1:0];
            if (wr_misc) pid_q <= csr_wdata[MISC_PID_LSB +: PID_W];
            if (wr_acc)  acc_q <= csr_wdata[ACC_W-1:0];
        end
    end

    // ---------------- read-back mux ----------------
    always_comb begin
        csr_rdata = '0;
        unique case (addr_e)
            CSR_PAGE: csr_rdata[VPN_W-1:0] = vpn_q;
            CSR_MISC: begin
                csr_rdata[MISC_PID_LSB +: PID_W] = pid_q;
                csr_rdata[MISC_WAY_LSB +: WAY_W] = way_q;
                csr_rdata[MISC_DBL_BIT]          = dbl_q;
                csr_rdata[MISC_WE_BIT]           = we_q;
            end
            CSR_ACC:  csr_rdata[ACC_W-1:0] = acc_q;
            CSR_NONE: csr_rdata = '0;
            default:  csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tlb_ctl_chk.sv
module tlb_ctl_chk #(
    parameter int NUM_WAYS = 4,
    parameter int ACC_W    = 24,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             csr_addr,
    input logic                   csr_wen,
    input logic [31:0]            csr_wdata,
    input logic                   exc_valid,
    input logic                   exc_tlb_miss,
    input logic                   exc_tlb_perm,
    input logic                   exc_dbl_miss,
    input logic                   exc_handler_active,
    input logic [WAY_W-1:0]       way_q,
    input logic                   we_q,
    input logic                   dbl_q,
    input logic [ACC_W-1:0]       acc_q,
    input tlb_ctl_pkg::rd_state_e state_q
);
    import tlb_ctl_pkg::*;

    localparam logic [WAY_W-1:0] LAST = WAY_W'(NUM_WAYS - 1);

    logic idle;
    assign idle = (state_q == ST_IDLE);

    assert_no_wr_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_LOAD) |-> !csr_wen);

    assert_load_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_LOAD) |=> (state_q == ST_IDLE));

    assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wen && idle && (csr_addr == 2'd0 ||
         (csr_addr == 2'd1 && !csr_wdata[MISC_RD_BIT]))) |=> $stable(acc_q));

    assert_way_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        {{(32-WAY_W){1'b0}}, way_q} < NUM_WAYS);

    assert_way_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wen && idle && csr_addr == 2'd2 && we_q) |=>
        (way_q == (($past(way_q) == LAST) ? '0 : $past(way_q) + 1'b1)));

    assert_no_commit_way_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wen && idle && csr_addr == 2'd2 && !we_q) |=> $stable(way_q));

    assert_we_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && (exc_tlb_perm || (exc_tlb_miss && !exc_handler_active))) |=> we_q);

    assert_dbl_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (dbl_q == $past(exc_dbl_miss)));
endmodule

bind tlb_ctl_regs tlb_ctl_chk #(
    .NUM_WAYS (NUM_WAYS),
    .ACC_W    (ACC_W)
) i_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .csr_addr           (csr_addr),
    .csr_wen            (csr_wen),
    .csr_wdata          (csr_wdata),
    .exc_valid          (exc_valid),
    .exc_tlb_miss       (exc_tlb_miss),
    .exc_tlb_perm       (exc_tlb_perm),
    .exc_dbl_miss       (exc_dbl_miss),
    .exc_handler_active (exc_handler_active),
    .way_q              (way_q),
    .we_q               (we_q),
    .dbl_q              (dbl_q),
    .acc_q              (acc_q),
    .state_q            (state_q)
);

// File: tb/test_tlb_ctl_regs.sv
module test_tlb_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic        csr_wen = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        exc_valid = 1'b0;
    logic        exc_tlb_miss = 1'b0;
    logic        exc_tlb_perm = 1'b0;
    logic        exc_dbl_miss = 1'b0;
    logic        exc_handler_active = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    tlb_ctl_regs i_tlb_ctl_regs (
        .clk                (clk),
        .rst_n              (rst_n),
        .csr_addr           (csr_addr),
        .csr_wen            (csr_wen),
        .csr_wdata          (csr_wdata),
        .csr_rdata          (csr_rdata),
        .exc_valid          (exc_valid),
        .exc_tlb_miss       (exc_tlb_miss),
        .exc_tlb_perm       (exc_tlb_perm),
        .exc_dbl_miss       (exc_dbl_miss),
        .exc_handler_active (exc_handler_active)
    );

    function automatic logic [31:0] misc(input logic [7:0] pid, input logic [3:0] way,
                                         input logic we, input logic dbl);
        return ({24'd0, pid} << 16) | ({28'd0, way} << 4) |
               ({31'd0, dbl} << 2) | ({31'd0, we} << 1);
    endfunction

    task automatic drive(input logic wen, input logic [1:0] a, input logic [31:0] d);
        @(posedge clk);
        #2;
        csr_wen = wen; csr_addr = a; csr_wdata = d;
        exc_valid = 1'b0; exc_tlb_miss = 1'b0; exc_tlb_perm = 1'b0;
        exc_dbl_miss = 1'b0; exc_handler_active = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        drive(1'b1, a, d);
    endtask

    task automatic idle();
        drive(1'b0, 2'd3, 32'd0);
    endtask

    task automatic chk(input logic [1:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        drive(1'b0, a, 32'd0);
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exc(input logic miss, input logic perm, input logic dbl, input logic eh);
        drive(1'b0, 2'd3, 32'd0);
        exc_valid = 1'b1; exc_tlb_miss = miss; exc_tlb_perm = perm;
        exc_dbl_miss = dbl; exc_handler_active = eh;
    endtask

    // monitor: pops the expected item and compares at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            total++;
            if (csr_rdata !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, csr_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        chk(2'd0, 32'd0, "R1 page after reset");
        chk(2'd1, 32'd0, "R1 control after reset");
        chk(2'd2, 32'd0, "R1 access after reset");
        wr(2'd1, 32'h1);
        idle();
        chk(2'd2, 32'd0, "R1 R8 entry invalid after reset");

        // R3, R5: commit into set 1 across all ways
        wr(2'd0, 32'h12345);
        wr(2'd1, misc(8'h21, 4'd0, 1'b1, 1'b0));
        wr(2'd2, 32'hABCDE1);
        chk(2'd2, 32'h00ABCDE1, "R3 access loaded on commit");
        chk(2'd1, misc(8'h21, 4'd1, 1'b1, 1'b0), "R5 way stepped");
        wr(2'd2, 32'h111111);
        wr(2'd2, 32'h222222);
        wr(2'd2, 32'h333333);
        chk(2'd1, misc(8'h21, 4'd0, 1'b1, 1'b0), "R5 way wrapped to 0");

        // R4: write-enable clear
        wr(2'd1, misc(8'h21, 4'd2, 1'b0, 1'b0));
        wr(2'd2, 32'h777777);
        chk(2'd2, 32'h00777777, "R4 access only");
        chk(2'd1, misc(8'h21, 4'd2, 1'b0, 1'b0), "R4 way held");
        wr(2'd1, misc(8'h21, 4'd2, 1'b0, 1'b0) | 32'h1);
        idle();
        chk(2'd2, 32'h00222222, "R4 entry untouched");

        // R2: field writes do not touch access register
        wr(2'd0, 32'h5);
        chk(2'd2, 32'h00222222, "R2 after page write");
        wr(2'd1, misc(8'h44, 4'd1, 1'b0, 1'b0));
        chk(2'd2, 32'h00222222, "R2 after control write");
        chk(2'd0, 32'h5, "R2 page written");

        // R7: read, entry PID wins
        wr(2'd1, misc(8'h99, 4'd1, 1'b0, 1'b0) | 32'h1);
        idle();
        chk(2'd2, 32'h00111111, "R7 access from entry");
        chk(2'd0, 32'h12345, "R7 page tag from entry");
        chk(2'd1, misc(8'h21, 4'd1, 1'b0, 1'b0), "R7 PID from entry wins");

        // R8: invalid entry
        wr(2'd0, 32'h3);
        wr(2'd1, misc(8'h55, 4'd0, 1'b0, 1'b0) | 32'h1);
        idle();
        chk(2'd2, 32'd0, "R8 access zero");
        chk(2'd0, 32'h3, "R8 set bits kept");
        chk(2'd1, 32'd0, "R8 PID zero");

        // R6: layout, out-of-range way, ignored bits
        wr(2'd1, 32'hFFFF_FFF6);
        chk(2'd1, 32'h00FF0002, "R6 masked readback");
        wr(2'd1, 32'h30);
        chk(2'd1, 32'h30, "R6 way 3");
        chk(2'd3, 32'd0, "R6 unused address");

        // R9, R10: exception flag updates
        exc(1'b1, 1'b0, 1'b1, 1'b1);
        chk(2'd1, misc(8'h0, 4'd3, 1'b0, 1'b1), "R9 miss in handler keeps WE, R10 dbl set");
        exc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(2'd1, misc(8'h0, 4'd3, 1'b1, 1'b0), "R9 miss sets WE, R10 dbl clear");
        wr(2'd1, 32'd0);
        exc(1'b0, 1'b1, 1'b0, 1'b1);
        chk(2'd1, misc(8'h0, 4'd0, 1'b1, 1'b0), "R9 permission sets WE");
        exc(1'b0, 1'b0, 1'b1, 1'b0);
        chk(2'd1, misc(8'h0, 4'd0, 1'b1, 1'b1), "R9 other keeps WE, R10 dbl set");

        // R9 with R3: hardware-set WE lets the handler commit
        wr(2'd0, 32'h8);
        wr(2'd2, 32'h5A5A5A);
        chk(2'd1, misc(8'h0, 4'd1, 1'b1, 1'b1), "R9 commit after exception");
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd0);
        chk(2'd2, 32'd0, "R4 access cleared without commit");
        wr(2'd1, 32'h1);
        idle();
        chk(2'd2, 32'h005A5A5A, "R3 entry stored by handler");
        chk(2'd0, 32'h8, "R7 page after read");

        idle();
        idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule